// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a small register window through which a host processor hands commands to a power-management microcontroller and gets results back. The host reaches it over a plain 32-bit register bus (byte address, write strobe, read strobe, write data, read data). A command word written at the command offset is latched, marks the mailbox busy and raises a one-cycle doorbell toward the responder. The opcode, subcommand, input byte count and interrupt-request flag are decoded from the latched word and presented to the responder, along with a four-word outbound data buffer that the host fills before it issues the command.

The responder writes result words into a four-word inbound buffer through its own port and finishes with a done strobe that carries an error flag and an 8-bit error code. Completion clears busy, records the outcome in the status register and sets a sticky completion flag. If the command asked for it, that flag drives the host interrupt. The host clears the flag by writing a one to its bit.

Top module: `host_cmd_mailbox`

## Requirements
- R1: A host write to byte offset 0x00 while not busy latches the 32-bit command word and sets busy. The doorbell output is high for exactly the one cycle after the accepting clock edge.
- R2: The responder sees fields decoded from the latched command: opcode = bits 7:0, interrupt request = bit 8, subcommand = bits 15:12, input length in bytes = bits 23:16.
- R3: Reading offset 0x04 returns status with busy in bit 0, error in bit 1, completion flag in bit 2, overrun in bit 3 and the error code in bits 23:16, with all other bits zero. Reads of offset 0x00 return the latched command. Reads of unmapped or non-word-aligned addresses return zero. Read data appears on the cycle after the clock edge that samples the read strobe.
- R4: A done strobe while busy clears busy, loads the error bit, loads the error code (or zero when no error is flagged), and sets the completion flag, all at the same edge. A done strobe while not busy changes nothing.
- R5: A status write clears the completion flag when data bit 2 is one and clears overrun when data bit 3 is one. Zero bits have no effect. When a done strobe arrives in the same cycle, the completion flag ends up set.
- R6: The host interrupt output equals the completion flag ANDed with the interrupt-request bit of the latched command.
- R7: A command write while busy is ignored: the latched command is kept and no doorbell pulse is produced. The write sets the sticky overrun flag.
- R8: The outbound buffer holds four words at offsets 0x80, 0x84, 0x88 and 0x8C. The host can read the buffer back, and the responder sees it as one vector with word 0 in the low 32 bits. Host writes to the buffer are ignored while busy.
- R9: The inbound buffer holds four words at offsets 0x90 to 0x9C and changes only when the responder writes a word by index. Host writes to it are ignored.
- R10: After reset, status, command, both buffers, read data, doorbell and interrupt are all zero.
- R11: An accepted command clears the error bit and the error code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 8 | Host byte address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, registered |
| host_irq | output | 1 | Completion interrupt to the host |
| doorbell | output | 1 | One-cycle pulse to the responder on a new command |
| req_opcode | output | 8 | Opcode of the latched command |
| req_irq_en | output | 1 | Interrupt request bit of the latched command |
| req_subcmd | output | 4 | Subcommand of the latched command |
| req_len | output | 8 | Input data length in bytes |
| req_data | output | 128 | Outbound buffer, word 0 in the low bits |
| rsp_wr | input | 1 | Responder write strobe for the inbound buffer |
| rsp_idx | input | 2 | Inbound word index |
| rsp_wdata | input | 32 | Responder result word |
| rsp_done | input | 1 | Completion strobe |
| rsp_err | input | 1 | Error flag sampled with the completion strobe |
| rsp_code | input | 8 | Error code sampled with the completion strobe |

## Verification
Every register update lands on the clock edge that samples its strobe. The doorbell, status bits, decoded fields and buffer contents therefore change one edge after the stimulus, and the interrupt follows the completion flag in that same cycle. Read data is registered, so a read strobe set up before an edge shows its result after that edge. The bench drives all inputs on the falling edge and samples on the next falling edge, which places every check half a cycle after the edge that produced it. The doorbell is checked on the first falling edge after the command edge and again one cycle later, where it must be low.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int MB_DATA_W = 32;
    localparam int MB_ADDR_W = 8;
    localparam int MB_WORDS  = 4;
    localparam int MB_CODE_W = 8;

    // register window (byte offsets)
    localparam int OFS_CMD = 'h00;
    localparam int OFS_STS = 'h04;
    localparam int OFS_OUT = 'h80;
    localparam int OFS_IN  = 'h90;

    // command word fields
    localparam int F_OPC_LSB = 0;
    localparam int F_OPC_W   = 8;
    localparam int F_IRQ_BIT = 8;
    localparam int F_SUB_LSB = 12;
    localparam int F_SUB_W   = 4;
    localparam int F_LEN_LSB = 16;
    localparam int F_LEN_W   = 8;

    // status word fields
    localparam int S_BUSY     = 0;
    localparam int S_ERR      = 1;
    localparam int S_DONE     = 2;
    localparam int S_OVR      = 3;
    localparam int S_CODE_LSB = 16;

    typedef struct packed {
        logic ovr;
        logic done;
        logic err;
        logic busy;
    } mb_flags_t;

endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
    import mbox_pkg::*;
#(
    parameter int DATA_W = MB_DATA_W,
    parameter int CODE_W = MB_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              sts_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rsp_done,
    input  logic              rsp_err,
    input  logic [CODE_W-1:0] rsp_code,
    output logic [DATA_W-1:0] cmd_word,
    output mb_flags_t         flags,
    output logic [CODE_W-1:0] err_code,
    output logic              bell
);

    typedef struct packed {
        logic [DATA_W-1:0] cmd;
        mb_flags_t         flg;
        logic [CODE_W-1:0] code;
        logic              bell;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bell = 1'b0;

        if (cmd_wr) begin
            if (st_q.flg.busy) begin
                st_d.flg.ovr = 1'b1;
            end else begin
                st_d.cmd      = wdata;
                st_d.flg.busy = 1'b1;
                st_d.flg.err  = 1'b0;
                st_d.code     = '0;
                st_d.bell     = 1'b1;
            end
        end

        if (sts_wr) begin
            if (wdata[S_DONE]) st_d.flg.done = 1'b0;
            if (wdata[S_OVR])  st_d.flg.ovr  = 1'b0;
        end

        // completion has priority over a simultaneous acknowledge
        if (rsp_done && st_q.flg.busy) begin
            st_d.flg.busy = 1'b0;
            st_d.flg.err  = rsp_err;
            st_d.code     = rsp_err ? rsp_code : '0;
            st_d.flg.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_word = st_q.cmd;
    assign flags    = st_q.flg;
    assign err_code = st_q.code;
    assign bell     = st_q.bell;

endmodule

// File: rtl/mbox_wordbuf.sv
module mbox_wordbuf
    import mbox_pkg::*;
#(
    parameter int WORDS  = MB_WORDS,
    parameter int DATA_W = MB_DATA_W,
    parameter int IDX_W  = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [WORDS*DATA_W-1:0] words
);

    logic [DATA_W-1:0] word_d [WORDS];
    logic [DATA_W-1:0] word_q [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_comb begin
            word_d[g] = word_q[g];
            if (wr_en && (wr_idx == IDX_W'(g))) word_d[g] = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q[g] <= '0;
            else        word_q[g] <= word_d[g];
        end

        assign words[g*DATA_W +: DATA_W] = word_q[g];
    end

endmodule

// File: rtl/mbox_hostif.sv
module mbox_hostif
    import mbox_pkg::*;
#(
    parameter int ADDR_W = MB_ADDR_W,
    parameter int DATA_W = MB_DATA_W,
    parameter int WORDS  = MB_WORDS,
    parameter int CODE_W = MB_CODE_W,
    parameter int IDX_W  = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    wr,
    input  logic                    rd,
    input  mb_flags_t               flags,
    input  logic [CODE_W-1:0]       err_code,
    input  logic [DATA_W-1:0]       cmd_word,
    input  logic [WORDS*DATA_W-1:0] out_words,
    input  logic [WORDS*DATA_W-1:0] in_words,
    output logic                    cmd_wr,
    output logic                    sts_wr,
    output logic                    out_wr,
    output logic [IDX_W-1:0]        idx,
    output logic [DATA_W-1:0]       rdata
);

    localparam int REGION_LSB = IDX_W + 2;

    localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(OFS_CMD);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STS);
    localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(OFS_OUT);
    localparam logic [ADDR_W-1:0] A_IN  = ADDR_W'(OFS_IN);

    logic aligned, hit_cmd, hit_sts, hit_out, hit_in;
    logic [DATA_W-1:0] sts_word;
    logic [DATA_W-1:0] rdata_d, rdata_q;

    assign aligned = (addr[1:0] == 2'b00);
    assign hit_cmd = aligned && (addr == A_CMD);
    assign hit_sts = aligned && (addr == A_STS);
    assign hit_out = aligned && (addr[ADDR_W-1:REGION_LSB] == A_OUT[ADDR_W-1:REGION_LSB]);
    assign hit_in  = aligned && (addr[ADDR_W-1:REGION_LSB] == A_IN[ADDR_W-1:REGION_LSB]);
    assign idx     = addr[REGION_LSB-1:2];

    assign cmd_wr = wr && hit_cmd;
    assign sts_wr = wr && hit_sts;
    assign out_wr = wr && hit_out && !flags.busy;

    always_comb begin
        sts_word                        = '0;
        sts_word[S_BUSY]                = flags.busy;
        sts_word[S_ERR]                 = flags.err;
        sts_word[S_DONE]                = flags.done;
        sts_word[S_OVR]                 = flags.ovr;
        sts_word[S_CODE_LSB +: CODE_W]  = err_code;
    end

    always_comb begin
        rdata_d = rdata_q;
        if (rd) begin
            if (hit_cmd)      rdata_d = cmd_word;
            else if (hit_sts) rdata_d = sts_word;
            else if (hit_out) rdata_d = out_words[idx*DATA_W +: DATA_W];
            else if (hit_in)  rdata_d = in_words[idx*DATA_W +: DATA_W];
            else              rdata_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/host_cmd_mailbox.sv
module host_cmd_mailbox
    import mbox_pkg::*;
#(
    parameter int ADDR_W = MB_ADDR_W,
    parameter int DATA_W = MB_DATA_W,
    parameter int WORDS  = MB_WORDS,
    parameter int CODE_W = MB_CODE_W,
    parameter int IDX_W  = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       host_addr,
    input  logic                    host_wr,
    input  logic                    host_rd,
    input  logic [DATA_W-1:0]       host_wdata,
    output logic [DATA_W-1:0]       host_rdata,
    output logic                    host_irq,
    output logic                    doorbell,
    output logic [F_OPC_W-1:0]      req_opcode,
    output logic                    req_irq_en,
    output logic [F_SUB_W-1:0]      req_subcmd,
    output logic [F_LEN_W-1:0]      req_len,
    output logic [WORDS*DATA_W-1:0] req_data,
    input  logic                    rsp_wr,
    input  logic [IDX_W-1:0]        rsp_idx,
    input  logic [DATA_W-1:0]       rsp_wdata,
    input  logic                    rsp_done,
    input  logic                    rsp_err,
    input  logic [CODE_W-1:0]       rsp_code
);

    logic                    cmd_wr, sts_wr, out_wr;
    logic [IDX_W-1:0]        host_idx;
    logic [DATA_W-1:0]       cmd_word;
    mb_flags_t               flags;
    logic [CODE_W-1:0]       err_code;
    logic [WORDS*DATA_W-1:0] out_words, in_words;

    mbox_hostif #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .CODE_W(CODE_W), .IDX_W(IDX_W)
    ) u_hostif (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (host_addr),
        .wr       (host_wr),
        .rd       (host_rd),
        .flags    (flags),
        .err_code (err_code),
        .cmd_word (cmd_word),
        .out_words(out_words),
        .in_words (in_words),
        .cmd_wr   (cmd_wr),
        .sts_wr   (sts_wr),
        .out_wr   (out_wr),
        .idx      (host_idx),
        .rdata    (host_rdata)
    );

    mbox_ctrl #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_wr  (cmd_wr),
        .sts_wr  (sts_wr),
        .wdata   (host_wdata),
        .rsp_done(rsp_done),
        .rsp_err (rsp_err),
        .rsp_code(rsp_code),
        .cmd_word(cmd_word),
        .flags   (flags),
        .err_code(err_code),
        .bell    (doorbell)
    );

    mbox_wordbuf #(.WORDS(WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_outbuf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (out_wr),
        .wr_idx (host_idx),
        .wr_data(host_wdata),
        .words  (out_words)
    );

    mbox_wordbuf #(.WORDS(WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_inbuf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (rsp_wr),
        .wr_idx (rsp_idx),
        .wr_data(rsp_wdata),
        .words  (in_words)
    );

    assign req_opcode = cmd_word[F_OPC_LSB +: F_OPC_W];
    assign req_irq_en = cmd_word[F_IRQ_BIT];
    assign req_subcmd = cmd_word[F_SUB_LSB +: F_SUB_W];
    assign req_len    = cmd_word[F_LEN_LSB +: F_LEN_W];
    assign req_data   = out_words;
    assign host_irq   = flags.done && req_irq_en;

endmodule

// File: rtl/mbox_checker.sv
module mbox_checker
    import mbox_pkg::*;
#(
    parameter int ADDR_W = MB_ADDR_W,
    parameter int DATA_W = MB_DATA_W,
    parameter int WORDS  = MB_WORDS
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-1:0]       host_addr,
    input logic                    host_wr,
    input logic [DATA_W-1:0]       host_wdata,
    input logic                    doorbell,
    input logic                    host_irq,
    input logic                    rsp_done,
    input logic [WORDS*DATA_W-1:0] req_data,
    input logic [DATA_W-1:0]       cmd_word,
    input mb_flags_t               flags
);

    logic cmd_access, sts_access;
    assign cmd_access = host_wr && (host_addr == ADDR_W'(OFS_CMD));
    assign sts_access = host_wr && (host_addr == ADDR_W'(OFS_STS));

    // R1: doorbell is a single-cycle pulse and coincides with busy
    assert_bell_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        doorbell |=> !doorbell);
    assert_bell_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        doorbell |-> flags.busy);

    // R4: busy holds until a done strobe; done ends it and flags completion
    assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flags.busy && !rsp_done) |=> flags.busy);
    assert_done_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flags.busy && rsp_done) |=> (!flags.busy && flags.done));

    // R5: acknowledge clears the completion flag unless a completion collides
    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_access && host_wdata[S_DONE] && !(rsp_done && flags.busy)) |=> !flags.done);

    // R6: interrupt only with the completion flag set
    assert_irq_needs_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> flags.done);

    // R7: command while busy leaves the command word and raises overrun
    assert_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_access && flags.busy) |=> (flags.ovr && !doorbell && $stable(cmd_word)));

    // R8: outbound buffer frozen while busy
    assert_outbuf_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flags.busy |=> $stable(req_data));

endmodule

bind host_cmd_mailbox mbox_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)
) u_mbox_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_addr (host_addr),
    .host_wr   (host_wr),
    .host_wdata(host_wdata),
    .doorbell  (doorbell),
    .host_irq  (host_irq),
    .rsp_done  (rsp_done),
    .req_data  (req_data),
    .cmd_word  (cmd_word),
    .flags     (flags)
);

// File: tb/tb_host_cmd_mailbox.sv
`timescale 1ns/1ps
module tb_host_cmd_mailbox;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   host_addr = '0;
    logic         host_wr = 1'b0;
    logic         host_rd = 1'b0;
    logic [31:0]  host_wdata = '0;
    logic [31:0]  host_rdata;
    logic         host_irq, doorbell, req_irq_en;
    logic [7:0]   req_opcode, req_len;
    logic [3:0]   req_subcmd;
    logic [127:0] req_data;
    logic         rsp_wr = 1'b0;
    logic [1:0]   rsp_idx = '0;
    logic [31:0]  rsp_wdata = '0;
    logic         rsp_done = 1'b0;
    logic         rsp_err = 1'b0;
    logic [7:0]   rsp_code = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;  // 125 MHz

    host_cmd_mailbox dut (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
        .doorbell(doorbell), .req_opcode(req_opcode), .req_irq_en(req_irq_en),
        .req_subcmd(req_subcmd), .req_len(req_len), .req_data(req_data),
        .rsp_wr(rsp_wr), .rsp_idx(rsp_idx), .rsp_wdata(rsp_wdata),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_code(rsp_code)
    );

    typedef struct packed {
        logic [7:0] opc;
        logic [3:0] sub;
        logic [7:0] len;
        logic       irq;
        logic       err;
        logic [7:0] code;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{opc: 8'h21, sub: 4'h3, len: 8'd16, irq: 1'b1, err: 1'b0, code: 8'h00},
        '{opc: 8'h05, sub: 4'h0, len: 8'd0,  irq: 1'b0, err: 1'b1, code: 8'h04},
        '{opc: 8'hff, sub: 4'hf, len: 8'd4,  irq: 1'b1, err: 1'b1, code: 8'h07},
        '{opc: 8'h40, sub: 4'ha, len: 8'd8,  irq: 1'b0, err: 1'b0, code: 8'h5a},
        '{opc: 8'h7e, sub: 4'h1, len: 8'd12, irq: 1'b1, err: 1'b1, code: 8'hff}
    };

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // all tasks are entered at a falling edge and return at a falling edge
    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic rsp_word(input logic [1:0] i, input logic [31:0] d);
        rsp_idx = i; rsp_wdata = d; rsp_wr = 1'b1;
        @(negedge clk);
        rsp_wr = 1'b0;
    endtask

    task automatic finish_cmd(input logic e, input logic [7:0] c);
        rsp_err = e; rsp_code = c; rsp_done = 1'b1;
        @(negedge clk);
        rsp_done = 1'b0;
    endtask

    function automatic logic [31:0] cmd_of(input vec_t v);
        return {8'h00, v.len, v.sub, 3'b000, v.irq, v.opc};
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [31:0] exp_sts;
        vec_t v;

        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 doorbell", 128'(doorbell), 0);
        chk("R10 irq", 128'(host_irq), 0);
        chk("R10 rdata", 128'(host_rdata), 0);
        chk("R10 req_data", req_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        bus_rd(8'h04, r); chk("R10 status", 128'(r), 0);
        bus_rd(8'h90, r); chk("R10 inbound", 128'(r), 0);

        // R8: outbound buffer fill and read back while idle
        for (int i = 0; i < 4; i++) bus_wr(8'(8'h80 + 4 * i), 32'h1100_0000 + 32'(i * 3));
        for (int i = 0; i < 4; i++) begin
            bus_rd(8'(8'h80 + 4 * i), r);
            chk("R8 outbound readback", 128'(r), 128'(32'h1100_0000 + 32'(i * 3)));
        end
        chk("R8 req_data order", req_data,
            {32'h1100_0009, 32'h1100_0006, 32'h1100_0003, 32'h1100_0000});

        // vector-driven transactions
        for (int k = 0; k < NV; k++) begin
            v = VECS[k];
            bus_wr(8'h00, cmd_of(v));
            chk("R1 doorbell high", 128'(doorbell), 1);
            chk("R2 opcode", 128'(req_opcode), 128'(v.opc));
            chk("R2 irq_en", 128'(req_irq_en), 128'(v.irq));
            chk("R2 subcmd", 128'(req_subcmd), 128'(v.sub));
            chk("R2 len", 128'(req_len), 128'(v.len));
            @(negedge clk);
            chk("R1 doorbell one cycle", 128'(doorbell), 0);
            bus_rd(8'h04, r); chk("R1 busy set / R11 clear err", 128'(r), 1);
            bus_rd(8'h00, r); chk("R3 command readback", 128'(r), 128'(cmd_of(v)));
            for (int i = 0; i < 4; i++) rsp_word(2'(i), {v.opc, 16'hA5C3, 8'(i + k)});
            finish_cmd(v.err, v.code);
            exp_sts = {8'h00, (v.err ? v.code : 8'h00), 12'h000, 4'b0100 | {2'b00, v.err, 1'b0}};
            chk("R6 irq follows request", 128'(host_irq), 128'(v.irq));
            bus_rd(8'h04, r); chk("R4 R3 status after done", 128'(r), 128'(exp_sts));
            for (int i = 0; i < 4; i++) begin
                bus_rd(8'(8'h90 + 4 * i), r);
                chk("R9 inbound word", 128'(r), 128'({v.opc, 16'hA5C3, 8'(i + k)}));
            end
            bus_wr(8'h04, 32'h0000_0004);
            chk("R5 R6 irq cleared", 128'(host_irq), 0);
            bus_rd(8'h04, r); chk("R5 done cleared", 128'(r), 128'(exp_sts & ~32'h4));
        end

        // directed: overrun, frozen buffers, collisions
        bus_wr(8'h00, 32'h0003_2111);  // opc 11, irq 1, sub 2, len 3
        @(negedge clk);
        bus_wr(8'h00, 32'h0000_0099);
        chk("R7 no doorbell on overrun", 128'(doorbell), 0);
        chk("R7 command kept", 128'(req_opcode), 128'(8'h11));
        bus_rd(8'h04, r); chk("R7 overrun flag", 128'(r), 128'(32'h9));
        bus_wr(8'h80, 32'hDEAD_BEEF);
        bus_rd(8'h80, r); chk("R8 write while busy ignored", 128'(r), 128'(32'h1100_0000));
        bus_wr(8'h94, 32'hCAFE_F00D);
        bus_rd(8'h94, r); chk("R9 host write to inbound ignored", 128'(r), 128'({8'h7e, 16'hA5C3, 8'd5}));
        bus_wr(8'h81, 32'h1234_5678);
        bus_rd(8'h81, r); chk("R3 unaligned read zero", 128'(r), 0);
        bus_rd(8'h40, r); chk("R3 unmapped read zero", 128'(r), 0);

        // completion collides with an acknowledge: completion wins
        rsp_err = 1'b1; rsp_code = 8'h33; rsp_done = 1'b1;
        host_addr = 8'h04; host_wdata = 32'h4; host_wr = 1'b1;
        @(negedge clk);
        rsp_done = 1'b0; host_wr = 1'b0;
        chk("R5 done wins collision irq", 128'(host_irq), 1);
        bus_wr(8'h04, 32'h0000_0000);
        bus_rd(8'h04, r); chk("R5 zero write no effect", 128'(r), 128'(32'h0033_000E));

        // done while idle ignored
        finish_cmd(1'b0, 8'h44);
        bus_rd(8'h04, r); chk("R4 done while idle ignored", 128'(r), 128'(32'h0033_000E));
        bus_wr(8'h04, 32'h0000_000C);
        bus_rd(8'h04, r); chk("R5 R7 W1C both flags", 128'(r), 128'(32'h0033_0002));

        // R11: new command clears the error state
        bus_wr(8'h00, 32'h0000_0001);
        bus_rd(8'h04, r); chk("R11 new command clears error", 128'(r), 1);
        finish_cmd(1'b0, 8'h00);
        chk("R6 no irq without request", 128'(host_irq), 0);

        summary();
        $finish;
    end

endmodule